// File: doc/BRIEF.md
# Cyclic Code Period and Seed Finder

This block accepts a K-bit value and builds a 2K-bit self-complementing codeword from it: the value in the upper half and its bitwise inverse in the lower half. Any cyclic rotation of such a word is again a word of the same code, so the rotations of one word form an equivalence class. The block walks that class one rotation per clock. It reports the smallest nonzero rotation distance that maps the word onto itself (its cyclic period), the numerically smallest member of the class (the canonical seed), and a flag that tells whether the input's own codeword already is that seed.

A request is made by raising `start_i` for one cycle with `word_i` valid while the block is not busy. The controller is a three-state machine. IDLE is the state after reset. IDLE goes to SPIN on an accepted start. In SPIN the working word rotates once per clock, and the running minimum is updated. SPIN goes to HOLD on the cycle where the next rotation equals the captured codeword, or when the rotation count reaches 2K as a guard. In HOLD the results are shown and `done_o` stays high. HOLD goes back to SPIN on a new start. A start seen in SPIN is dropped. Because the rotations repeat with the period, the walk stops after exactly `period` rotations, and the minimum is already complete at that point.

Top module: `refl_period_seed`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `is_seed_o`, `period_o` and `seed_o` are all zero.
- R2: The codeword of input x is {x, ~x}: x in bits 2K-1..K and its bitwise inverse in bits K-1..0. Every reported seed therefore has exactly K ones. For x = 0 the seed is {K zeros, K ones}.
- R3: `period_o` is the smallest p > 0 for which rotating the codeword by p positions returns the same word. For K = 6, x = 110001 gives 12 and x = 110011 gives 4.
- R4: The reported period divides 2K, does not divide K, and is at least twice the largest power of two that divides K.
- R5: `seed_o` is the minimum unsigned value among all 2K rotations of the codeword.
- R6: `is_seed_o` is 1 exactly when `seed_o` equals the input's own codeword.
- R7: A start accepted at clock edge E raises `busy_o` after E. `busy_o` stays high for exactly `period` cycles. `done_o` rises, with the results, `period` edges after E. `busy_o` and `done_o` are never high together.
- R8: `start_i` has no effect while `busy_o` is high. The run completes with the results and timing of the word that was first accepted.
- R9: While in HOLD and with no start, `done_o` and all result outputs keep their values. A start in HOLD drops `done_o` and raises `busy_o` after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a search; accepted only when not busy |
| word_i | input | K | Value whose codeword is analysed, sampled with an accepted start |
| busy_o | output | 1 | Search in progress (SPIN) |
| done_o | output | 1 | Results valid (HOLD) |
| period_o | output | $clog2(2K+1) | Smallest cyclic period of the codeword |
| seed_o | output | 2K | Smallest rotation of the codeword |
| is_seed_o | output | 1 | Input's codeword equals the seed |

## Verification
Two events can fall in the same cycle: the early stop, where the next rotation matches the captured word, and the rotation-count guard reaching 2K. They coincide for every word whose period is the full 2K. Such words, like 110001 and the all-zero input, provoke the overlap. The run is judged correct when it stops exactly once, after 2K cycles, with period 2K. A second overlap is a start arriving while HOLD still shows the previous results. The bench issues a new request on a cycle where `done_o` is high and checks that `done_o` drops and `busy_o` rises on the same edge, and then that the new word's results appear.

// File: rtl/refl_pkg.sv
package refl_pkg;

    // Controller states of the period and seed search
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SPIN = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_e;

endpackage

// File: rtl/refl_codeword.sv
// Forms the self-complementing codeword {x, ~x}.
module refl_codeword #(
    parameter int K = 6,
    localparam int W = 2 * K
) (
    input  logic [K-1:0] value_i,
    output logic [W-1:0] code_o
);

    for (genvar g = 0; g < K; g++) begin : g_half
        assign code_o[K + g] = value_i[g];
        assign code_o[g]     = ~value_i[g];
    end

endmodule

// File: rtl/refl_rotor.sv
// Holds the captured codeword, the rotating copy and the running minimum.
module refl_rotor #(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] code_i,
    output logic [W-1:0] orig_o,
    output logic [W-1:0] min_o,
    output logic         match_o
);

    logic [W-1:0] orig_q;
    logic [W-1:0] rot_q;
    logic [W-1:0] min_q;
    logic [W-1:0] rot_nxt;

    // one-position left rotation of the working word
    assign rot_nxt = {rot_q[W-2:0], rot_q[W-1]};
    assign match_o = (rot_nxt == orig_q);
    assign orig_o  = orig_q;
    assign min_o   = min_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            orig_q <= '0;
            rot_q  <= '0;
            min_q  <= '0;
        end else if (load_i) begin
            orig_q <= code_i;
            rot_q  <= code_i;
            min_q  <= code_i;
        end else if (step_i) begin
            rot_q <= rot_nxt;
            if (rot_nxt < min_q) begin
                min_q <= rot_nxt;
            end
        end
    end

endmodule

// File: rtl/refl_ctrl.sv
// Three-state sequencer: IDLE -> SPIN -> HOLD -> SPIN ...
module refl_ctrl
    import refl_pkg::*;
#(
    parameter int W = 12,
    localparam int PW = $clog2(W + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          match_i,
    output logic          load_o,
    output logic          step_o,
    output logic          finish_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [PW-1:0] steps_o
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic [PW-1:0] cnt_q;
    logic          at_limit;

    assign at_limit = (cnt_q == PW'(W - 1));
    assign steps_o  = cnt_q + PW'(1);

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_SPIN;
            ST_SPIN: if (match_i || at_limit) state_d = ST_HOLD;
            ST_HOLD: if (start_i) state_d = ST_SPIN;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o   = 1'b0;
        step_o   = 1'b0;
        finish_o = 1'b0;
        busy_o   = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = start_i;
            ST_SPIN: begin
                busy_o   = 1'b1;
                step_o   = 1'b1;
                finish_o = match_i || at_limit;
            end
            ST_HOLD: begin
                done_o = 1'b1;
                load_o = start_i;
            end
            default: ;
        endcase
    end

    // rotation counter
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_o) begin
            cnt_q <= '0;
        end else if (step_o) begin
            cnt_q <= steps_o;
        end
    end

endmodule

// File: rtl/refl_result.sv
// Captures period, seed and seed flag when a search finishes.
module refl_result #(
    parameter int W = 12,
    localparam int PW = $clog2(W + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          finish_i,
    input  logic [PW-1:0] steps_i,
    input  logic [W-1:0]  min_i,
    input  logic [W-1:0]  orig_i,
    output logic [PW-1:0] period_o,
    output logic [W-1:0]  seed_o,
    output logic          is_seed_o
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            period_o  <= '0;
            seed_o    <= '0;
            is_seed_o <= 1'b0;
        end else if (finish_i) begin
            period_o  <= steps_i;
            seed_o    <= min_i;
            is_seed_o <= (min_i == orig_i);
        end
    end

endmodule

// File: rtl/refl_period_seed.sv
module refl_period_seed #(
    parameter int K = 6,
    localparam int W = 2 * K,
    localparam int PW = $clog2(W + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [K-1:0]  word_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [PW-1:0] period_o,
    output logic [W-1:0]  seed_o,
    output logic          is_seed_o
);

    logic [W-1:0]  code_w;
    logic [W-1:0]  orig_w;
    logic [W-1:0]  min_w;
    logic [PW-1:0] steps_w;
    logic          match_w;
    logic          load_w;
    logic          step_w;
    logic          finish_w;

    refl_codeword #(.K(K)) u_code (
        .value_i (word_i),
        .code_o  (code_w)
    );

    refl_ctrl #(.W(W)) u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start_i),
        .match_i  (match_w),
        .load_o   (load_w),
        .step_o   (step_w),
        .finish_o (finish_w),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .steps_o  (steps_w)
    );

    refl_rotor #(.W(W)) u_rotor (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load_w),
        .step_i  (step_w),
        .code_i  (code_w),
        .orig_o  (orig_w),
        .min_o   (min_w),
        .match_o (match_w)
    );

    refl_result #(.W(W)) u_result (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .finish_i  (finish_w),
        .steps_i   (steps_w),
        .min_i     (min_w),
        .orig_i    (orig_w),
        .period_o  (period_o),
        .seed_o    (seed_o),
        .is_seed_o (is_seed_o)
    );

endmodule

// File: rtl/refl_checker.sv
module refl_checker #(
    parameter int K = 6,
    localparam int W = 2 * K,
    localparam int PW = $clog2(W + 1)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic [PW-1:0] period_o,
    input logic [W-1:0]  seed_o,
    input logic          is_seed_o,
    input logic [W-1:0]  orig
);

    function automatic int low_pow2(input int n);
        int p = 1;
        while ((n % (2 * p)) == 0) p = 2 * p;
        return p;
    endfunction

    localparam int MINP = 2 * low_pow2(K);

    assert_busy_done_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_o && done_o));

    assert_run_ends_in_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> (busy_o || done_o));

    assert_period_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (int'(period_o) >= MINP) && ((W % int'(period_o)) == 0)
                   && ((K % int'(period_o)) != 0));

    assert_seed_weight_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($countones(seed_o) == K));

    assert_seed_not_above_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (seed_o <= orig));

    assert_flag_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && is_seed_o) |-> (seed_o == orig));

    assert_flag_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !is_seed_o) |-> (seed_o < orig));

    assert_hold_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> (done_o && $stable(period_o) && $stable(seed_o)
                                  && $stable(is_seed_o)));

    assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> $stable(orig));

endmodule

bind refl_period_seed refl_checker #(.K(K)) u_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .period_o  (period_o),
    .seed_o    (seed_o),
    .is_seed_o (is_seed_o),
    .orig      (orig_w)
);

// File: tb/test_refl_period_seed.sv
`timescale 1ns/1ps
module test_refl_period_seed;

    localparam int K  = 6;
    localparam int W  = 2 * K;
    localparam int PW = $clog2(W + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [K-1:0]  word = '0;
    logic          busy;
    logic          done;
    logic [PW-1:0] period;
    logic [W-1:0]  seed;
    logic          is_seed;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    refl_period_seed #(.K(K)) i_refl_period_seed (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .start_i   (start),
        .word_i    (word),
        .busy_o    (busy),
        .done_o    (done),
        .period_o  (period),
        .seed_o    (seed),
        .is_seed_o (is_seed)
    );

    // ---------------- reference model ----------------
    function automatic logic [W-1:0] ref_code(input logic [K-1:0] v);
        return {v, ~v};
    endfunction

    function automatic logic [W-1:0] rot_r(input logic [W-1:0] v);
        return {v[0], v[W-1:1]};
    endfunction

    function automatic int ref_period(input logic [K-1:0] v);
        logic [W-1:0] c = ref_code(v);
        logic [W-1:0] r = c;
        for (int i = 1; i <= W; i++) begin
            r = rot_r(r);
            if (r == c) return i;
        end
        return 0;
    endfunction

    function automatic logic [W-1:0] ref_seed(input logic [K-1:0] v);
        logic [W-1:0] r = ref_code(v);
        logic [W-1:0] m = r;
        for (int i = 1; i < W; i++) begin
            r = rot_r(r);
            if (r < m) m = r;
        end
        return m;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // start at a negedge, returns after the start edge at the following negedge
    task automatic issue(input logic [K-1:0] v);
        @(negedge clk);
        word  = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // counts negedges until done; called at the negedge right after the start edge
    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_reset();
        check(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
        check(period == 0 && seed == 0 && is_seed == 0, "R1 results", seed, 0);
    endtask

    task automatic t_run(input logic [K-1:0] v, input string tag);
        int lat;
        int ep = ref_period(v);
        logic [W-1:0] es = ref_seed(v);
        issue(v);
        check(busy == 1 && done == 0, {tag, " R7 busy after start"}, {busy, done}, 2'b10);
        wait_done(lat);
        check(int'(period) == ep, {tag, " R3 period"}, period, ep);
        check(seed == es, {tag, " R5 seed"}, seed, es);
        check(is_seed == (es == ref_code(v)), {tag, " R6 flag"}, is_seed, (es == ref_code(v)));
        check(lat == ep, {tag, " R7 latency"}, lat, ep);
    endtask

    task automatic t_examples();
        t_run(6'b110001, "ex1");
        check(period == 12, "R3 110001 period 12", period, 12);
        t_run(6'b110011, "ex2");
        check(period == 4, "R3 110011 period 4", period, 4);
        check(period >= 4 && (12 % int'(period)) == 0 && (6 % int'(period)) != 0,
              "R4 period legal", period, 4);
        t_run(6'b000000, "zero");
        check(seed == 12'b000000111111, "R2 zero seed", seed, 12'b000000111111);
        check(is_seed == 1, "R6 zero is own seed", is_seed, 1);
        t_run(6'b111111, "ones");
        check(seed == 12'b000000111111 && is_seed == 0, "R2 R6 ones seed",
              {is_seed, seed}, 12'b000000111111);
    endtask

    task automatic t_all_words();
        for (int v = 0; v < (1 << K); v++) begin
            t_run(K'(v), "sweep R4");
            check($countones(seed) == K, "R2 seed weight", $countones(seed), K);
        end
    endtask

    task automatic t_start_while_busy();
        int lat;
        issue(6'b110001);
        for (int i = 0; i < 3; i++) begin
            word  = 6'b110011;
            start = 1'b1;
            @(negedge clk);
            lat = i;
        end
        start = 1'b0;
        word  = 6'b000011;
        wait_done(lat);
        lat = lat + 3;
        check(int'(period) == 12, "R8 period of first word", period, 12);
        check(seed == ref_seed(6'b110001), "R8 seed of first word", seed, ref_seed(6'b110001));
        check(lat == 12, "R8 timing unchanged", lat, 12);
    endtask

    task automatic t_hold();
        logic [PW-1:0] p0 = period;
        logic [W-1:0]  s0 = seed;
        logic          f0 = is_seed;
        for (int i = 0; i < 6; i++) begin
            word = K'(i * 7 + 1);
            @(negedge clk);
        end
        check(done == 1 && busy == 0, "R9 done held", {busy, done}, 2'b01);
        check(period == p0 && seed == s0 && is_seed == f0, "R9 results held", seed, s0);
    endtask

    task automatic t_restart_from_hold();
        int lat;
        check(done == 1, "R9 in HOLD before restart", done, 1);
        issue(6'b101010);
        check(done == 0 && busy == 1, "R9 restart drops done", {busy, done}, 2'b10);
        wait_done(lat);
        check(int'(period) == ref_period(6'b101010), "R9 R3 restart period",
              period, ref_period(6'b101010));
        check(seed == ref_seed(6'b101010), "R9 R5 restart seed", seed, ref_seed(6'b101010));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_examples();
        t_all_words();
        t_start_while_busy();
        t_hold();
        t_restart_from_hold();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_checks++;
                n_fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
                $finish;
            end
        end
    end

endmodule